// File: doc/BRIEF.md
# Restoring Sign-Magnitude Divider

This block divides a double-length sign-magnitude dividend by a single-length sign-magnitude divisor. It uses restoring division, one quotient bit per clock. The dividend magnitude is split into a high half that seeds the partial-remainder register and a low half that seeds the quotient register. On each step the combined carry, remainder and quotient register shifts left by one place. The divisor is then subtracted by adding its two's complement, and the carry out decides whether the new quotient bit is one or whether the old remainder is kept.

Before the iterations begin, the block tests whether the high half of the dividend is greater than or equal to the divisor. That single comparison catches both a quotient too wide for the output and a zero divisor. When it fires, the divide-overflow flag rises and the operation ends at once. A caller pulses `start_i` while the block is idle, sees `busy_o` while it works, and reads the results when `done_o` pulses for one cycle. The results then stay on the outputs until the next start.

Top module: `rdiv_sm_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `ovf_o` are 0 and both magnitude outputs are 0.
- R2: A `start_i` sampled high while idle captures all operands, and `busy_o` is 1 from the next clock edge.
- R3: When the upper MAG_W bits of the dividend magnitude are greater than or equal to the divisor magnitude (a zero divisor always qualifies), `ovf_o` becomes 1 and `done_o` pulses on the first clock edge after the start edge.
- R4: Without overflow, `quo_mag_o` equals the integer quotient of the dividend and divisor magnitudes and `rem_mag_o` equals the remainder; `done_o` pulses on the edge MAG_W+1 edges after the start edge.
- R5: `quo_sign_o` is the exclusive OR of the dividend sign and the divisor sign (1 means negative).
- R6: `rem_sign_o` equals the dividend sign, even when the remainder is zero.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle.
- R8: `start_i` asserted while `busy_o` is 1 is ignored; the running division finishes with its original operands.
- R9: `ovf_o` is cleared by every accepted start, so a normal division after an overflow reports `ovf_o` = 0.
- R10: While idle and without a new start, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division (accepted only when idle) |
| dvd_sign_i | input | 1 | Dividend sign, 1 = negative |
| dvd_mag_i | input | 2*MAG_W | Dividend magnitude |
| dvs_sign_i | input | 1 | Divisor sign, 1 = negative |
| dvs_mag_i | input | MAG_W | Divisor magnitude |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Divide overflow (includes zero divisor) |
| quo_sign_o | output | 1 | Quotient sign |
| quo_mag_o | output | MAG_W | Quotient magnitude |
| rem_sign_o | output | 1 | Remainder sign |
| rem_mag_o | output | MAG_W | Remainder magnitude |

## Verification
The bench builds the block with the default MAG_W of 5, which gives a 10-bit dividend and a 5-bit divisor. At that size, the exact overflow boundary is easy to place: a high half one below the divisor, and a high half equal to it. The largest quotient (31) and a zero divisor are also easy to reach. So are iterations in which the bit shifted out of the remainder is 1 and forces an unconditional subtract. A table of directed cases and a stream of pseudo-random operands are compared against integer division and modulo computed in the bench.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ITER  = 2'd2
    } rdiv_state_e;

endpackage

// File: rtl/rdiv_addsub.sv
module rdiv_addsub #(
    parameter int W = 5
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W-1:0] b_x;
    logic [W:0]   c;

    // complementer: ones' complement of b when subtracting, carry-in supplies the +1
    assign b_x  = b_i ^ {W{sub_i}};
    assign c[0] = sub_i;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_o[i] = a_i[i] ^ b_x[i] ^ c[i];
        assign c[i+1]   = (a_i[i] & b_x[i]) | (c[i] & (a_i[i] ^ b_x[i]));
    end

    assign carry_o = c[W];

endmodule

// File: rtl/rdiv_seq_counter.sv
module rdiv_seq_counter #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CW'(LIMIT);
        end else if (dec_i) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CW'(1));

    // R4: a step is never taken with the count exhausted
    a_r4_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));

    // R4: a load always yields the full number of quotient steps
    a_r4_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == CW'(LIMIT)));

endmodule

// File: rtl/rdiv_sm_divider.sv
module rdiv_sm_divider
    import rdiv_pkg::*;
#(
    parameter int MAG_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 dvd_sign_i,
    input  logic [2*MAG_W-1:0]   dvd_mag_i,
    input  logic                 dvs_sign_i,
    input  logic [MAG_W-1:0]     dvs_mag_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 ovf_o,
    output logic                 quo_sign_o,
    output logic [MAG_W-1:0]     quo_mag_o,
    output logic                 rem_sign_o,
    output logic [MAG_W-1:0]     rem_mag_o
);

    localparam int DVD_W = 2 * MAG_W;

    typedef struct packed {
        rdiv_state_e      st;
        logic [MAG_W-1:0] acc;
        logic [MAG_W-1:0] quo;
        logic [MAG_W-1:0] dvs;
        logic             qs;
        logic             rs;
        logic             ovf;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    logic             sh_e;
    logic [MAG_W-1:0] sh_acc;
    logic [MAG_W-1:0] sh_quo;
    logic [MAG_W-1:0] add_a;
    logic [MAG_W-1:0] add_sum;
    logic             add_carry;
    logic             ctr_load;
    logic             ctr_dec;
    logic             ctr_last;

    // left shift of the carry/remainder/quotient chain; 0 enters the quotient LSB
    assign sh_e   = r_q.acc[MAG_W-1];
    assign sh_acc = {r_q.acc[MAG_W-2:0], r_q.quo[MAG_W-1]};
    assign sh_quo = {r_q.quo[MAG_W-2:0], 1'b0};

    // overflow test uses the unshifted high half, steps use the shifted remainder
    assign add_a = (r_q.st == ST_CHECK) ? r_q.acc : sh_acc;

    rdiv_addsub #(.W(MAG_W)) i_addsub (
        .a_i     (add_a),
        .b_i     (r_q.dvs),
        .sub_i   (1'b1),
        .sum_o   (add_sum),
        .carry_o (add_carry)
    );

    rdiv_seq_counter #(.LIMIT(MAG_W)) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ctr_load),
        .dec_i  (ctr_dec),
        .last_o (ctr_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.acc = dvd_mag_i[DVD_W-1:MAG_W];
                    r_d.quo = dvd_mag_i[MAG_W-1:0];
                    r_d.dvs = dvs_mag_i;
                    r_d.qs  = dvd_sign_i ^ dvs_sign_i;
                    r_d.rs  = dvd_sign_i;
                    r_d.ovf = 1'b0;
                    r_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (add_carry) begin
                    // high half >= divisor: abort, remainder register left untouched
                    r_d.ovf  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    // difference discarded, so the restore is free
                    ctr_load = 1'b1;
                    r_d.st   = ST_ITER;
                end
            end
            ST_ITER: begin
                ctr_dec = 1'b1;
                r_d.quo = sh_quo;
                if (sh_e || add_carry) begin
                    r_d.acc    = add_sum;
                    r_d.quo[0] = 1'b1;
                end else begin
                    r_d.acc = sh_acc;
                end
                if (ctr_last) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign ovf_o      = r_q.ovf;
    assign quo_sign_o = r_q.qs;
    assign quo_mag_o  = r_q.quo;
    assign rem_sign_o = r_q.rs;
    assign rem_mag_o  = r_q.acc;

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    a_r3_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> done_o);

    a_r3_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHECK && r_q.dvs == '0) |=> (ovf_o && done_o));

    a_r5_sign_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ITER) |=> ($stable(quo_sign_o) && $stable(rem_sign_o)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quo_mag_o) && $stable(rem_mag_o) && $stable(ovf_o)));

endmodule

// File: tb/test_rdiv_sm_divider.sv
module test_rdiv_sm_divider;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 5;
    localparam int DW         = 2 * W;
    localparam int NTBL       = 12;

    localparam int unsigned TBL_DVD [NTBL] = '{437, 0, 1023, 991, 100, 5, 31, 32, 500, 1000, 255, 700};
    localparam int unsigned TBL_DVS [NTBL] = '{19,  7, 31,   31,  0,   3, 1,  1,  17,  0,    9,   22};
    localparam logic        TBL_SD  [NTBL] = '{0, 1, 0, 1, 0, 1, 1, 0, 0, 1, 1, 0};
    localparam logic        TBL_SS  [NTBL] = '{0, 0, 1, 1, 1, 0, 1, 0, 1, 0, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          dvd_sign_i = 1'b0;
    logic [DW-1:0] dvd_mag_i = '0;
    logic          dvs_sign_i = 1'b0;
    logic [W-1:0]  dvs_mag_i = '0;
    logic          busy_o, done_o, ovf_o, quo_sign_o, rem_sign_o;
    logic [W-1:0]  quo_mag_o, rem_mag_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdiv_sm_divider #(.MAG_W(W)) i_rdiv_sm_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dvd_sign_i (dvd_sign_i),
        .dvd_mag_i  (dvd_mag_i),
        .dvs_sign_i (dvs_sign_i),
        .dvs_mag_i  (dvs_mag_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ovf_o      (ovf_o),
        .quo_sign_o (quo_sign_o),
        .quo_mag_o  (quo_mag_o),
        .rem_sign_o (rem_sign_o),
        .rem_mag_o  (rem_mag_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // drives one division; optional disturbance start with other operands while busy (R8)
    task automatic run_div(input logic sd, input int unsigned dd, input logic ss,
                           input int unsigned ds, input bit disturb);
        int unsigned hi, eq, er;
        bit          eo;
        int          lat;
        hi = dd >> W;
        eo = (hi >= ds);
        eq = eo ? 0 : dd / ds;
        er = eo ? 0 : dd % ds;
        @(negedge clk);
        dvd_sign_i = sd;
        dvd_mag_i  = dd[DW-1:0];
        dvs_sign_i = ss;
        dvs_mag_i  = ds[W-1:0];
        start_i    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        lat = 0;
        while (!done_o && lat < 4 * W) begin
            if (disturb && lat == 1) begin
                dvd_mag_i = 10'd3;
                dvs_mag_i = 5'd2;
                dvd_sign_i = ~sd;
                dvs_sign_i = 1'b0;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        chk(ovf_o == eo, eo ? "R3 overflow flag" : "R9 overflow flag clear", int'(ovf_o), int'(eo));
        chk(lat == (eo ? 1 : W + 1), eo ? "R3 abort latency" : "R4 latency", lat, eo ? 1 : W + 1);
        chk(busy_o == 1'b0, "R7 not busy at done", int'(busy_o), 0);
        if (!eo) begin
            chk(quo_mag_o == eq[W-1:0], disturb ? "R8 quotient" : "R4 quotient", int'(quo_mag_o), int'(eq));
            chk(rem_mag_o == er[W-1:0], disturb ? "R8 remainder" : "R4 remainder", int'(rem_mag_o), int'(er));
            chk(quo_sign_o == (sd ^ ss), "R5 quotient sign", int'(quo_sign_o), int'(sd ^ ss));
            chk(rem_sign_o == sd, "R6 remainder sign", int'(rem_sign_o), int'(sd));
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done single cycle", int'(done_o), 0);
        if (!eo) begin
            repeat (2) @(negedge clk);
            chk(quo_mag_o == eq[W-1:0] && rem_mag_o == er[W-1:0], "R10 results held",
                int'(quo_mag_o), int'(eq));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy_o == 0 && done_o == 0 && ovf_o == 0, "R1 reset flags",
            int'({busy_o, done_o, ovf_o}), 0);
        chk(quo_mag_o == 0 && rem_mag_o == 0, "R1 reset magnitudes", int'(quo_mag_o) + int'(rem_mag_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NTBL; i++) begin
            run_div(TBL_SD[i], TBL_DVD[i], TBL_SS[i], TBL_DVS[i], 1'b0);
        end

        // R8: start pulsed mid-run is ignored
        run_div(1'b1, 600, 1'b0, 23, 1'b1);

        // R9: overflow followed by a normal division
        run_div(1'b0, 64, 1'b0, 2, 1'b0);
        run_div(1'b0, 63, 1'b0, 2, 1'b0);

        // R3 boundary: high half one below and equal to divisor
        run_div(1'b0, (13 << W) | 31, 1'b1, 14, 1'b0);
        run_div(1'b1, (14 << W), 1'b1, 14, 1'b0);

        seed = 32'h1234_5678;
        for (int k = 0; k < 60; k++) begin
            int unsigned dd, ds;
            seed = seed * 32'd1103515245 + 32'd12345;
            dd = (seed >> 8) & 32'h3FF;
            seed = seed * 32'd1103515245 + 32'd12345;
            ds = (seed >> 8) & 32'h1F;
            run_div(seed[3], dd, seed[5], ds, 1'b0);
        end

        finish_run();
    end

endmodule